// File: doc/BRIEF.md
# Video Matrix Column and Row Span Counters

This block tracks how much of the character matrix is left on the current line and in the current frame. It holds two counters that only count upward. Each one is preset with the bitwise inverse of its target and counts until every bit is one, at which point a last-value flag goes high. No comparator is involved. Flag logic only has to detect the all-ones state.

The column counter is 8 bits wide. At the start of each line it is preset from a 7-bit column count with a forced zero below it. The preset value is therefore the inverse of twice the column count. It then advances once per enabled cycle. The row counter is 6 bits wide. It is preset from a 6-bit row count when the line counter wraps back to the top of the frame, and it advances once for each finished character row. Both counters stop at all ones and do not wrap.

Top module: `mtx_span_ctr`

## Requirements
- R1: After reset both counters sit at all ones, so `col_last_o` and `row_last_o` are both 1.
- R2: A cycle with `line_start_i` high presets the column counter to the bitwise inverse of {`col_cnt_i`, 1'b0}. For a count of 22 this is 211, and `col_last_o` is 0 afterwards for any nonzero count.
- R3: Each cycle with `col_adv_i` high and no line start adds one to the column counter. After a preset with count N > 0, `col_last_o` is 0 after 2N−1 advances and 1 after exactly 2N advances.
- R4: The column counter saturates at 255. Once `col_last_o` is 1, it stays 1 under further advances until the next line start.
- R5: A line start in the same cycle as `col_adv_i` performs the preset only, and that advance is lost.
- R6: A cycle with `frame_wrap_i` high presets the row counter to the bitwise inverse of `row_cnt_i`. After a preset with count M > 0, `row_last_o` is 0 after M−1 `row_done_i` pulses and 1 after exactly M pulses.
- R7: The row counter saturates at 63. Once `row_last_o` is 1, it stays 1 under further `row_done_i` pulses until the next frame wrap.
- R8: A frame wrap in the same cycle as `row_done_i` performs the preset only, and that pulse is lost.
- R9: A count of zero presets a counter directly to all ones, so its last-value flag is 1 in the cycle after the preset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| col_cnt_i | input | 7 | Number of matrix columns |
| row_cnt_i | input | 6 | Number of matrix rows |
| line_start_i | input | 1 | Start-of-line strobe, presets the column counter |
| frame_wrap_i | input | 1 | Last-to-first line wrap strobe, presets the row counter |
| col_adv_i | input | 1 | Column advance enable |
| row_done_i | input | 1 | Character row finished pulse |
| col_last_o | output | 1 | Column counter is at all ones |
| row_last_o | output | 1 | Row counter is at all ones |

## Verification
The assertions assume that the count inputs are stable in every cycle that carries a preset strobe. The flag checks after a preset use those same cycle values. The bench sets each count field before it raises the matching strobe and keeps the field steady through that cycle. It also mixes a strobe with a same-cycle advance or done pulse, so the priority cases fall inside what the assertions describe.

// File: rtl/mtx_span_ctr.sv
module mtx_span_ctr #(
  parameter int COL_W = 7,
  parameter int ROW_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COL_W-1:0] col_cnt_i,
  input  logic [ROW_W-1:0] row_cnt_i,
  input  logic             line_start_i,
  input  logic             frame_wrap_i,
  input  logic             col_adv_i,
  input  logic             row_done_i,
  output logic             col_last_o,
  output logic             row_last_o
);
  localparam int CW = COL_W + 1;

  logic [CW-1:0]    col_q;
  logic [ROW_W-1:0] row_q;

  assign col_last_o = &col_q;
  assign row_last_o = &row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      col_q <= '1;
    else if (line_start_i)
      col_q <= ~{col_cnt_i, 1'b0};
    else if (col_adv_i && !col_last_o)
      col_q <= col_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      row_q <= '1;
    else if (frame_wrap_i)
      row_q <= ~row_cnt_i;
    else if (row_done_i && !row_last_o)
      row_q <= row_q + 1'b1;
  end

  a_r2_col_preset: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_i && (col_cnt_i != '0) |=> !col_last_o);
  a_r9_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_i && (col_cnt_i == '0) |=> col_last_o);
  a_r4_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
    col_last_o && !line_start_i |=> col_last_o);
  a_r5_col_priority: assert property (@(posedge clk) disable iff (!rst_n)
    line_start_i && col_adv_i && (col_cnt_i != '0) |=> !col_last_o);
  a_r6_row_preset: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap_i && (row_cnt_i != '0) |=> !row_last_o);
  a_r7_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
    row_last_o && !frame_wrap_i |=> row_last_o);
  a_r8_row_priority: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap_i && row_done_i && (row_cnt_i != '0) |=> !row_last_o);
  a_r3_col_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start_i && !col_adv_i |=> $stable(col_last_o));
endmodule

// File: tb/sim_mtx_span_ctr.sv
module sim_mtx_span_ctr;
  logic clk = 0, rst_n = 0;
  logic [6:0] col_cnt = 0;
  logic [5:0] row_cnt = 0;
  logic line_start = 0, frame_wrap = 0, col_adv = 0, row_done = 0;
  logic col_last, row_last;
  int tests = 0, fails = 0;
  int mc = 255, mr = 63;
  bit finished = 0;

  always #2 clk = ~clk;

  mtx_span_ctr u0 (
    .clk(clk), .rst_n(rst_n), .col_cnt_i(col_cnt), .row_cnt_i(row_cnt),
    .line_start_i(line_start), .frame_wrap_i(frame_wrap),
    .col_adv_i(col_adv), .row_done_i(row_done),
    .col_last_o(col_last), .row_last_o(row_last));

  always @(posedge clk) begin
    if (!rst_n) begin
      mc = 255; mr = 63;
    end else begin
      if (line_start) mc = 255 - 2 * int'(col_cnt);
      else if (col_adv && mc < 255) mc = mc + 1;
      if (frame_wrap) mr = 63 - int'(row_cnt);
      else if (row_done && mr < 63) mr = mr + 1;
    end
  end

  task automatic chk(input logic got, input logic exp, input string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk(col_last, mc == 255, "model R3 column flag");
    chk(row_last, mr == 63, "model R6 row flag");
  end

  task automatic cyc(); @(negedge clk); endtask

  task automatic col_run(input int n);
    col_cnt = 7'(n); line_start = 1; cyc(); line_start = 0;
    if (n == 0) chk(col_last, 1, "R9 zero columns");
    else begin
      chk(col_last, 0, "R2 preset");
      col_adv = 1;
      repeat (2 * n - 1) cyc();
      chk(col_last, 0, "R3 one short");
      cyc();
      chk(col_last, 1, "R3 exact 2N");
      repeat (3) cyc();
      chk(col_last, 1, "R4 saturate");
      col_adv = 0;
    end
  endtask

  task automatic row_run(input int m);
    row_cnt = 6'(m); frame_wrap = 1; cyc(); frame_wrap = 0;
    if (m == 0) chk(row_last, 1, "R9 zero rows");
    else begin
      chk(row_last, 0, "R6 preset");
      for (int i = 0; i < m - 1; i++) begin
        row_done = 1; cyc(); row_done = 0; cyc();
      end
      chk(row_last, 0, "R6 one short");
      row_done = 1; cyc(); row_done = 0; cyc();
      chk(row_last, 1, "R6 exact M");
      row_done = 1; repeat (2) cyc(); row_done = 0;
      chk(row_last, 1, "R7 saturate");
    end
  endtask

  initial begin
    repeat (3) cyc();
    rst_n = 1;
    cyc();
    chk(col_last, 1, "R1 column reset");
    chk(row_last, 1, "R1 row reset");
    col_run(22);
    col_run(1);
    col_run(127);
    col_run(0);
    col_run(9);
    col_adv = 1; col_cnt = 5; line_start = 1; cyc(); line_start = 0;
    repeat (9) cyc();
    chk(col_last, 0, "R5 advance lost on preset");
    cyc();
    chk(col_last, 1, "R5 full span after preset");
    col_adv = 0;
    row_run(23);
    row_run(1);
    row_run(0);
    row_run(63);
    row_cnt = 3; frame_wrap = 1; row_done = 1; cyc(); frame_wrap = 0;
    cyc(); row_done = 0;
    chk(row_last, 0, "R8 pulse lost on preset");
    row_done = 1; cyc(); row_done = 0; cyc();
    chk(row_last, 0, "R8 two of three");
    row_done = 1; cyc(); row_done = 0; cyc();
    chk(row_last, 1, "R8 full rows after preset");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    finished = 1;
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule